// File: doc/BRIEF.md
# Read-Order Cartridge Mode Switcher

This block sits on a cartridge bus and watches the halfword reads the host issues. A fixed chain of ten read addresses selects the memory mapping that the cartridge presents. The eighth read is different from the others: any even address in the 0x08xxxxxx window is accepted there, and address bits [23:1] of that read carry a mode code. The mapping changes only when the tenth read of the chain completes. Writes play no part in the chain. The one exception is a single magic write, which goes straight to the read-write RAM mapping.

While the ROM mapping is active, reads at window offsets of 0x200 and above come back as all ones. This lasts until the host issues a short follow-up chain of four reads. The block gates the read data it returns for the window. It also publishes the active mapping, a RAM-writable flag and the high-offset unlock flag, and the surrounding memories and media logic use these.

Top module: `cart_mode_sequencer`

## Requirements
- R1: After reset the mapping is ROM (`map_sel` = 0), `hi_unlocked` is 0 and `ram_writable` is 0.
- R2: Ten reads issued in order complete the mode chain, and the new mapping is visible on the cycle after the tenth read. The byte addresses are 0x08E00002, 0x0800000E, 0x08801FFC, 0x0800104A, 0x08800612, 0x08000000, 0x08801B66, then (0x08000000 + 2·mode), then 0x0800080E and 0x08000000.
- R3: Only the low nibble of the mode code (address bits [4:1] of the eighth read) selects the mapping. The values are 4 for ROM (`map_sel` 0), 3 for media (1), 2 for read-only RAM (2) and 6 for read-write RAM (3). `ram_writable` is 1 only for read-write RAM. Any other nibble completes the chain but leaves the mapping unchanged.
- R4: A read that does not match the expected next address restarts the chain. If that read equals the first address of the chain, it counts as step 1. This rule applies to the unlock chain as well.
- R5: An aborted chain leaves the mapping unchanged.
- R6: A write of 0xAA55 to byte address 0x09FFEFFE selects read-write RAM on the next cycle and wins over a chain completing in the same cycle. Other data or other addresses have no effect.
- R7: In ROM mode while locked, a read in 0x08000000–0x09FFFFFF at window offset (address bits [24:0]) of 0x200 or more returns 0xFFFF in the same cycle. Lower offsets and reads outside the window pass `mem_rdata` through.
- R8: In locked ROM mode, the reads 0x080001E4, 0x080001E4, 0x08000188, 0x08000188 set `hi_unlocked` on the cycle after the fourth read, and high offsets then pass through.
- R9: Any change of mapping and any completed mode chain clear `hi_unlocked`. No blocking applies outside ROM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Halfword read on the bus this cycle |
| wr_valid | input | 1 | Halfword write on the bus this cycle |
| bus_addr | input | 32 | Byte address of the access |
| wr_data | input | 16 | Write data |
| mem_rdata | input | 16 | Data from the mapped memory |
| bus_rdata | output | 16 | Read data returned to the host, gated when locked |
| map_sel | output | 2 | Active mapping: 0 ROM, 1 media, 2 RAM read-only, 3 RAM read-write |
| ram_writable | output | 1 | RAM mapping accepts writes |
| hi_unlocked | output | 1 | ROM offsets at 0x200 and above are readable |

## Verification
The mapping, `ram_writable` and `hi_unlocked` are registered, so each one changes on the first clock edge after the read or write that completes its chain. The bench drives each access from one falling edge to the next and samples these outputs at that second falling edge. `bus_rdata` is combinational from the current read, so the bench checks it one time unit after driving the read, before the edge that follows. The chain aborts and the restart-on-first-address cases are checked the same way, one cycle after the final read of the attempt.

// File: rtl/cart_mode_pkg.sv
package cart_mode_pkg;

  localparam int ADDR_W    = 32;
  localparam int MAIN_LEN  = 10;
  localparam int UNLK_LEN  = 4;
  localparam int MODE_STEP = 7;

  typedef enum logic [1:0] {
    MAP_ROM    = 2'd0,
    MAP_MEDIA  = 2'd1,
    MAP_RAM_RO = 2'd2,
    MAP_RAM_RW = 2'd3
  } map_e;

  typedef struct packed {
    logic valid;
    map_e map;
  } mode_dec_t;

  // address compare under a care-mask
  function automatic logic addr_match(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] pat,
                                      input logic [ADDR_W-1:0] mask);
    return ((a ^ pat) & mask) == '0;
  endfunction

  // low nibble of the mode code to a mapping
  function automatic mode_dec_t decode_mode(input logic [3:0] nib);
    mode_dec_t d;
    d.valid = 1'b1;
    d.map   = MAP_ROM;
    case (nib)
      4'h4:    d.map = MAP_ROM;
      4'h3:    d.map = MAP_MEDIA;
      4'h2:    d.map = MAP_RAM_RO;
      4'h6:    d.map = MAP_RAM_RW;
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

  // high ROM offsets hidden while locked
  function automatic logic hi_blocked(input logic [ADDR_W-1:0] a,
                                      input int unsigned limit);
    return (a[31:25] == 7'h04) && (a[24:0] >= 25'(limit));
  endfunction

endpackage

// File: rtl/seq_matcher.sv
module seq_matcher
  import cart_mode_pkg::*;
#(
  parameter int LEN = 4,
  localparam int SW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        rd_valid,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LEN-1:0][ADDR_W-1:0]  pat,
  input  logic [LEN-1:0][ADDR_W-1:0]  mask,
  output logic [SW-1:0]               step,
  output logic                        step_hit,
  output logic                        done
);

  localparam logic [SW-1:0] LAST = SW'(LEN - 1);

  logic [SW-1:0] step_q;
  logic          cur_ok;
  logic          first_ok;

  always_comb begin
    cur_ok   = addr_match(addr, pat[step_q], mask[step_q]);
    first_ok = addr_match(addr, pat[0], mask[0]);
  end

  assign step_hit = enable && rd_valid && cur_ok;
  assign done     = step_hit && (step_q == LAST);
  assign step     = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      step_q <= '0;
    end else if (rd_valid) begin
      if (cur_ok)
        step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
      else
        step_q <= first_ok ? SW'(1) : '0;
    end
  end

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import cart_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic [3:0] cap_nib,
  input  logic       seq_done,
  input  logic       wr_hit,
  input  logic       unlk_done,
  output map_e       map_q,
  output logic       unlocked_q
);

  logic [3:0] pend_nib;
  mode_dec_t  dec;

  always_comb dec = decode_mode(pend_nib);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_nib   <= 4'h4;
      map_q      <= MAP_ROM;
      unlocked_q <= 1'b0;
    end else begin
      if (cap_en) pend_nib <= cap_nib;
      if (wr_hit) begin
        map_q      <= MAP_RAM_RW;
        unlocked_q <= 1'b0;
      end else if (seq_done) begin
        if (dec.valid) map_q <= dec.map;
        unlocked_q <= 1'b0;
      end else if (unlk_done) begin
        unlocked_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cart_mode_sequencer.sv
module cart_mode_sequencer
  import cart_mode_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LOCK_LIMIT = 32'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              wr_valid,
  input  logic [31:0]       bus_addr,
  input  logic [15:0]       wr_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        map_sel,
  output logic              ram_writable,
  output logic              hi_unlocked
);

  localparam logic [ADDR_W-1:0] FULL = '1;
  localparam logic [ADDR_W-1:0] MODE_MASK = 32'hFF00_0001;
  localparam logic [ADDR_W-1:0] RW_ADDR = 32'h09FF_EFFE;
  localparam logic [15:0]       RW_KEY  = 16'hAA55;

  localparam logic [MAIN_LEN-1:0][ADDR_W-1:0] MAIN_PAT = {
    32'h0800_0000, 32'h0800_080E, 32'h0800_0000, 32'h0880_1B66,
    32'h0800_0000, 32'h0880_0612, 32'h0800_104A, 32'h0880_1FFC,
    32'h0800_000E, 32'h08E0_0002 };

  localparam logic [UNLK_LEN-1:0][ADDR_W-1:0] UNLK_PAT = {
    32'h0800_0188, 32'h0800_0188, 32'h0800_01E4, 32'h0800_01E4 };

  logic [MAIN_LEN-1:0][ADDR_W-1:0] main_mask;
  logic [UNLK_LEN-1:0][ADDR_W-1:0] unlk_mask;

  for (genvar i = 0; i < MAIN_LEN; i++) begin : g_main_mask
    assign main_mask[i] = (i == MODE_STEP) ? MODE_MASK : FULL;
  end
  for (genvar j = 0; j < UNLK_LEN; j++) begin : g_unlk_mask
    assign unlk_mask[j] = FULL;
  end

  logic [$clog2(MAIN_LEN)-1:0] main_step;
  logic [$clog2(UNLK_LEN)-1:0] unlk_step;
  logic main_hit, seq_done, unlk_hit, unlk_done, unlk_en;
  logic cap_en, wr_hit, rd_block;
  map_e map_q;
  logic unlocked_q;

  assign unlk_en = (map_q == MAP_ROM) && !unlocked_q;

  seq_matcher #(.LEN(MAIN_LEN)) u_main (
    .clk(clk), .rst_n(rst_n), .enable(1'b1), .rd_valid(rd_valid),
    .addr(bus_addr), .pat(MAIN_PAT), .mask(main_mask),
    .step(main_step), .step_hit(main_hit), .done(seq_done));

  seq_matcher #(.LEN(UNLK_LEN)) u_unlk (
    .clk(clk), .rst_n(rst_n), .enable(unlk_en), .rd_valid(rd_valid),
    .addr(bus_addr), .pat(UNLK_PAT), .mask(unlk_mask),
    .step(unlk_step), .step_hit(unlk_hit), .done(unlk_done));

  assign cap_en = main_hit && (main_step == ($clog2(MAIN_LEN))'(MODE_STEP));
  assign wr_hit = wr_valid && (bus_addr == RW_ADDR) && (wr_data == RW_KEY);

  mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_nib(bus_addr[4:1]),
    .seq_done(seq_done), .wr_hit(wr_hit), .unlk_done(unlk_done),
    .map_q(map_q), .unlocked_q(unlocked_q));

  assign rd_block = rd_valid && unlk_en && hi_blocked(bus_addr, LOCK_LIMIT);

  assign bus_rdata    = rd_block ? {DATA_W{1'b1}} : mem_rdata;
  assign map_sel      = map_q;
  assign ram_writable = (map_q == MAP_RAM_RW);
  assign hi_unlocked  = unlocked_q;

endmodule

// File: rtl/cart_mode_checker.sv
module cart_mode_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_valid,
  input logic       seq_done,
  input logic       wr_hit,
  input logic       unlk_done,
  input logic [1:0] map_sel,
  input logic       hi_unlocked
);

  AST_DONE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> rd_valid); // R2

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_done && !wr_hit) |=> $stable(map_sel)); // R5

  AST_WRITE_RW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (map_sel == 2'd3)); // R6

  AST_UNLOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_unlocked) |-> $past(unlk_done)); // R8

  AST_UNLOCK_ROM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    hi_unlocked |-> (map_sel == 2'd0)); // R9

endmodule

bind cart_mode_sequencer cart_mode_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .seq_done(seq_done),
  .wr_hit(wr_hit), .unlk_done(unlk_done), .map_sel(map_sel),
  .hi_unlocked(hi_unlocked));

// File: tb/cart_mode_sequencer_bench.sv
module cart_mode_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] mem_rdata = 16'h1234;
  logic [15:0] bus_rdata;
  logic [1:0]  map_sel;
  logic        ram_writable;
  logic        hi_unlocked;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cart_mode_sequencer u_cart_mode_sequencer (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .wr_valid(wr_valid),
    .bus_addr(bus_addr), .wr_data(wr_data), .mem_rdata(mem_rdata),
    .bus_rdata(bus_rdata), .map_sel(map_sel), .ram_writable(ram_writable),
    .hi_unlocked(hi_unlocked));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] chain_addr(input int k, input logic [22:0] mode);
    case (k)
      0: return 32'h08E00002;
      1: return 32'h0800000E;
      2: return 32'h08801FFC;
      3: return 32'h0800104A;
      4: return 32'h08800612;
      5: return 32'h08000000;
      6: return 32'h08801B66;
      7: return 32'h08000000 + {8'h0, mode, 1'b0};
      8: return 32'h0800080E;
      default: return 32'h08000000;
    endcase
  endfunction

  task automatic rd(input logic [31:0] a);
    @(negedge clk);
    rd_valid = 1'b1; bus_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; bus_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic chain(input logic [22:0] mode);
    for (int k = 0; k < 10; k++) rd(chain_addr(k, mode));
  endtask

  task automatic peek(input string req, input logic [31:0] a, input logic [15:0] exp);
    @(negedge clk);
    rd_valid = 1'b1; bus_addr = a; mem_rdata = 16'h1234;
    #1;
    chk(req, bus_rdata, exp);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 map", map_sel, 0);
    chk("R1 unlock", hi_unlocked, 0);
    chk("R1 writable", ram_writable, 0);
  endtask

  task automatic t_modes;
    chain(23'h400003); chk("R2 media", map_sel, 1);
    chain(23'h400002); chk("R3 ram ro", map_sel, 2);
    chk("R3 ro not writable", ram_writable, 0);
    chain(23'h400006); chk("R3 ram rw", map_sel, 3);
    chk("R3 rw writable", ram_writable, 1);
    chain(23'h400004); chk("R3 rom", map_sel, 0);
    chain(23'h000013); chk("R3 low nibble only", map_sel, 1);
    chain(23'h400005); chk("R3 unknown nibble keeps", map_sel, 1);
  endtask

  task automatic t_abort;
    for (int k = 0; k < 9; k++) rd(chain_addr(k, 23'h2));
    rd(32'h08001000);
    chk("R5 abort keeps", map_sel, 1);
    rd(chain_addr(9, 23'h2));
    chk("R5 stray tail keeps", map_sel, 1);
  endtask

  task automatic t_restart;
    rd(chain_addr(0, 23'h2)); rd(chain_addr(1, 23'h2));
    for (int k = 0; k < 10; k++) rd(chain_addr(k, 23'h2));
    chk("R4 restart on first", map_sel, 2);
    rd(chain_addr(0, 23'h3)); rd(32'h08000100);
    for (int k = 1; k < 10; k++) rd(chain_addr(k, 23'h3));
    chk("R4 mismatch restarts", map_sel, 2);
  endtask

  task automatic t_write;
    chain(23'h4);
    wr(32'h09FFEFFE, 16'h1234); chk("R6 wrong data", map_sel, 0);
    wr(32'h09FFEFFC, 16'hAA55); chk("R6 wrong addr", map_sel, 0);
    wr(32'h09FFEFFE, 16'hAA55); chk("R6 key write", map_sel, 3);
    chk("R6 writable", ram_writable, 1);
  endtask

  task automatic t_lock;
    chain(23'h4);
    peek("R7 high blocked", 32'h08000200, 16'hFFFF);
    peek("R7 far high blocked", 32'h09F00000, 16'hFFFF);
    peek("R7 low passes", 32'h080001FE, 16'h1234);
    peek("R7 outside window", 32'h0A000400, 16'h1234);
    rd(32'h080001E4); rd(32'h080001E4); rd(32'h080001E4);
    rd(32'h08000188); rd(32'h08000188);
    chk("R4 unlock triple restart", hi_unlocked, 0);
    rd(32'h080001E4); rd(32'h080001E4); rd(32'h08000188); rd(32'h08000188);
    chk("R8 unlocked", hi_unlocked, 1);
    peek("R8 high passes", 32'h08000200, 16'h1234);
    chain(23'h4);
    chk("R9 chain relocks", hi_unlocked, 0);
    peek("R9 blocked again", 32'h08000200, 16'hFFFF);
    chain(23'h3);
    peek("R9 media no block", 32'h08000200, 16'h1234);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_abort();
        t_restart();
        t_write();
        t_lock();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule